// File: doc/BRIEF.md
# Landing Pad Control-Flow Checker

This block guards the indirect-jump path of a small RV32 core. The core presents each instruction to the checker just before executing it, together with its PC and the current contents of register x7. When an indirect jump needs a landing pad, the checker records that fact in an expected-pad flag and captures a 20-bit label from the upper bits of x7. The next instruction presented must then be a valid pad. If it is not, the checker raises a software-check exception request in the same cycle, and the core suppresses that instruction.

The enable bit and the saved copy of the expected-pad flag are held here as well. The core reads and writes them through a small CSR port. It pulses trap and return strobes so that the flag is saved on exception entry and restored on `mret`.

Top module: `lpad_cfi_checker`

## Requirements
- R1: After reset the CSR at 0x747 and the CSR at 0x310 read 0, and no exception is requested for any instruction.
- R2: Bit 10 of CSR 0x747 is the enable and bit 9 of CSR 0x310 is the saved flag. Both can be written and read back. All other bits of those CSRs, and every other CSR address, read 0.
- R3: With the enable set, a 32-bit instruction (bits 1:0 = 11) with bits 6:0 = 0x67 and bits 14:12 = 0 arms the expected-pad flag, unless bits 19:15 are 1, 5 or 7. Any other funct3 does not arm it.
- R4: With the enable set, a 16-bit instruction with bits 1:0 = 10 and bits 15:12 equal to 8 or 9 arms the flag, unless bits 11:7 are 1, 5 or 7. Other quadrants and other values of bits 15:12 do not arm it.
- R5: While the flag is armed, an instruction passes only if three conditions hold. Its bits 11:0 are 0x017, its PC bits 1:0 are 0, and its bits 31:12 are zero or equal to bits 31:12 of x7 captured when the flag was armed.
- R6: A failed pad check drives the exception request high in the same cycle as the instruction, with cause 18 and trap value 2. The flag stays armed.
- R7: A passing pad clears the flag, so a following ordinary instruction raises no exception.
- R8: With the enable clear, no jump arms the flag and no exception is raised.
- R9: A trap pulse stores (flag AND enable) into the saved bit and clears the flag.
- R10: An mret pulse sets the flag to (saved bit AND enable) and clears the saved bit. The captured label is kept across the trap and return.
- R11: The exception request is never high in a cycle without a valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction is about to execute |
| instWord | input | 32 | Instruction bits (16-bit forms in the low half) |
| instPc | input | 32 | Address of that instruction |
| x7Value | input | 32 | Current contents of register x7 |
| trapEnter | input | 1 | Core enters a trap this cycle |
| mretDone | input | 1 | Core executes mret this cycle |
| csrWe | input | 1 | CSR write strobe |
| csrAddr | input | 12 | CSR address for read and write |
| csrWdata | input | 32 | CSR write data |
| excValid | output | 1 | Landing-pad fault request |
| excCause | output | 32 | Exception cause (18 when valid) |
| excTval | output | 32 | Trap value (2 when valid) |
| csrRdata | output | 32 | CSR read data for csrAddr |

## Verification
The bench builds the block with its defaults: 32-bit data, a 20-bit label and compressed decode enabled. Those defaults bring both jump encodings within reach, along with the full label comparison, including the zero-label wildcard and a mismatching label. With them the bench drives armed and unarmed jumps through the excluded link registers, misaligned and malformed pads, and the save and restore of the flag with the enable set or clear. Whether the flag is armed is observed through the exception raised by a following ordinary instruction.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  typedef struct packed {
    logic retireOk;
    logic armPad;
    logic padFault;
    logic trapSave;
    logic mretRestore;
    logic wrSeccfg;
    logic wrStatush;
  } lpadStrobes_t;
endpackage

// File: rtl/lpad_ctrl.sv
module lpad_ctrl
  import lpad_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LABEL_W = 20,
  parameter int CSR_AW = 12,
  parameter logic [CSR_AW-1:0] SECCFG_ADDR = 12'h747,
  parameter logic [CSR_AW-1:0] STATUSH_ADDR = 12'h310,
  parameter bit HAS_COMPRESSED = 1'b1,
  parameter int FAULT_CAUSE = 18,
  parameter int FAULT_TVAL = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic instValid,
  input  logic [XLEN-1:0] instWord,
  input  logic [XLEN-1:0] instPc,
  input  logic elp,
  input  logic mlpe,
  input  logic [LABEL_W-1:0] label,
  input  logic trapEnter,
  input  logic mretDone,
  input  logic csrWe,
  input  logic [CSR_AW-1:0] csrAddr,
  output lpadStrobes_t strobes,
  output logic excValid,
  output logic [XLEN-1:0] excCause,
  output logic [XLEN-1:0] excTval
);
  localparam int LOW_W = XLEN - LABEL_W;
  localparam logic [LOW_W-1:0] PAD_LOW = LOW_W'(12'h017);

  logic [4:0] wideRs1;
  logic wideJump;
  logic wideNeeds;
  logic shortNeeds;
  logic needsPad;
  logic padLowOk;
  logic padAligned;
  logic [LABEL_W-1:0] padLabel;
  logic padLabelOk;
  logic padOk;
  logic faultNow;

  function automatic logic isLinkReg(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5) || (r == 5'd7);
  endfunction

  // 32-bit register-indirect jump
  assign wideRs1 = instWord[19:15];
  assign wideJump = (instWord[1:0] == 2'b11) && (instWord[6:0] == 7'h67) &&
                    (instWord[14:12] == 3'b000);
  assign wideNeeds = wideJump && !isLinkReg(wideRs1);

  generate
    if (HAS_COMPRESSED) begin : g_short
      logic [4:0] shortRs1;
      logic shortJump;
      assign shortRs1 = instWord[11:7];
      assign shortJump = (instWord[1:0] == 2'b10) &&
                         ((instWord[15:12] == 4'h8) || (instWord[15:12] == 4'h9));
      assign shortNeeds = shortJump && !isLinkReg(shortRs1);
    end else begin : g_noShort
      assign shortNeeds = 1'b0;
    end
  endgenerate

  assign needsPad = wideNeeds || shortNeeds;

  // pad acceptance
  assign padLowOk = (instWord[LOW_W-1:0] == PAD_LOW);
  assign padAligned = (instPc[1:0] == 2'b00);
  assign padLabel = instWord[XLEN-1 -: LABEL_W];
  assign padLabelOk = (padLabel == label) || (padLabel == '0);
  assign padOk = padLowOk && padAligned && padLabelOk;

  assign faultNow = instValid && elp && mlpe && !padOk;

  always_comb begin
    strobes = '0;
    strobes.padFault = faultNow;
    strobes.trapSave = trapEnter;
    strobes.mretRestore = mretDone && !trapEnter;
    strobes.retireOk = instValid && !faultNow && !trapEnter && !mretDone;
    strobes.armPad = mlpe && needsPad;
    strobes.wrSeccfg = csrWe && (csrAddr == SECCFG_ADDR);
    strobes.wrStatush = csrWe && (csrAddr == STATUSH_ADDR);
  end

  assign excValid = faultNow;
  assign excCause = faultNow ? XLEN'(FAULT_CAUSE) : '0;
  assign excTval = faultNow ? XLEN'(FAULT_TVAL) : '0;

  logic [XLEN-1:0] unusedPc;
  assign unusedPc = instPc;

  AST_EXC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> instValid); // R11
  AST_EXC_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (elp && mlpe)); // R6
  AST_EXC_CODES: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excCause == XLEN'(FAULT_CAUSE) && excTval == XLEN'(FAULT_TVAL))); // R6
endmodule

// File: rtl/lpad_dp.sv
module lpad_dp
  import lpad_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LABEL_W = 20,
  parameter int CSR_AW = 12,
  parameter logic [CSR_AW-1:0] SECCFG_ADDR = 12'h747,
  parameter logic [CSR_AW-1:0] STATUSH_ADDR = 12'h310,
  parameter int ENABLE_BIT = 10,
  parameter int SAVED_BIT = 9
) (
  input  logic clk,
  input  logic rstN,
  input  lpadStrobes_t strobes,
  input  logic [XLEN-1:0] x7Value,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic [XLEN-1:0] csrWdata,
  output logic elp,
  output logic mlpe,
  output logic [LABEL_W-1:0] label,
  output logic [XLEN-1:0] csrRdata
);
  logic mpelp;
  logic [LABEL_W-1:0] x7Label;

  assign x7Label = x7Value[XLEN-1 -: LABEL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elp <= 1'b0;
      mlpe <= 1'b0;
      mpelp <= 1'b0;
      label <= '0;
    end else begin
      if (strobes.wrSeccfg) mlpe <= csrWdata[ENABLE_BIT];
      if (strobes.trapSave) begin
        mpelp <= elp & mlpe;
        elp <= 1'b0;
      end else if (strobes.mretRestore) begin
        elp <= mpelp & mlpe;
        mpelp <= 1'b0;
      end else begin
        if (strobes.wrStatush) mpelp <= csrWdata[SAVED_BIT];
        if (strobes.retireOk) begin
          elp <= strobes.armPad;
          if (strobes.armPad) label <= x7Label;
        end
      end
    end
  end

  always_comb begin
    csrRdata = '0;
    if (csrAddr == SECCFG_ADDR) csrRdata[ENABLE_BIT] = mlpe;
    else if (csrAddr == STATUSH_ADDR) csrRdata[SAVED_BIT] = mpelp;
  end

  logic [XLEN-1:0] unusedX7;
  assign unusedX7 = x7Value;

  AST_TRAP_CLEARS_ELP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trapSave |=> !elp); // R9
  AST_TRAP_SAVES_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trapSave |=> (mpelp == $past(elp && mlpe))); // R9
  AST_MRET_CLEARS_SAVED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mretRestore |=> !mpelp); // R10
  AST_ELP_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(elp) |-> $past(mlpe)); // R8
  AST_FAULT_KEEPS_ELP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.padFault && !strobes.trapSave && !strobes.mretRestore) |=> elp); // R6
endmodule

// File: rtl/lpad_cfi_checker.sv
module lpad_cfi_checker
  import lpad_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LABEL_W = 20,
  parameter int CSR_AW = 12,
  parameter bit HAS_COMPRESSED = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic instValid,
  input  logic [XLEN-1:0] instWord,
  input  logic [XLEN-1:0] instPc,
  input  logic [XLEN-1:0] x7Value,
  input  logic trapEnter,
  input  logic mretDone,
  input  logic csrWe,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic [XLEN-1:0] csrWdata,
  output logic excValid,
  output logic [XLEN-1:0] excCause,
  output logic [XLEN-1:0] excTval,
  output logic [XLEN-1:0] csrRdata
);
  lpadStrobes_t strobes;
  logic elp;
  logic mlpe;
  logic [LABEL_W-1:0] label;

  lpad_ctrl #(
    .XLEN(XLEN), .LABEL_W(LABEL_W), .CSR_AW(CSR_AW), .HAS_COMPRESSED(HAS_COMPRESSED)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .instPc(instPc), .elp(elp), .mlpe(mlpe), .label(label),
    .trapEnter(trapEnter), .mretDone(mretDone), .csrWe(csrWe), .csrAddr(csrAddr),
    .strobes(strobes), .excValid(excValid), .excCause(excCause), .excTval(excTval)
  );

  lpad_dp #(
    .XLEN(XLEN), .LABEL_W(LABEL_W), .CSR_AW(CSR_AW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .x7Value(x7Value),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .elp(elp), .mlpe(mlpe),
    .label(label), .csrRdata(csrRdata)
  );
endmodule

// File: tb/lpad_cfi_checker_tb.sv
module lpad_cfi_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [31:0] JALR_X6 = 32'h0003_0067;
  localparam logic [31:0] X7A = 32'h1234_5000;

  logic clk = 0;
  logic rstN = 0;
  logic instValid = 0;
  logic [31:0] instWord = 0, instPc = 0, x7Value = 0;
  logic trapEnter = 0, mretDone = 0, csrWe = 0;
  logic [11:0] csrAddr = 0;
  logic [31:0] csrWdata = 0;
  logic excValid;
  logic [31:0] excCause, excTval, csrRdata;

  int checks = 0;
  int failures = 0;
  logic sExc;
  logic [31:0] sCause, sTval;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpad_cfi_checker dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .instPc(instPc), .x7Value(x7Value), .trapEnter(trapEnter), .mretDone(mretDone),
    .csrWe(csrWe), .csrAddr(csrAddr), .csrWdata(csrWdata), .excValid(excValid),
    .excCause(excCause), .excTval(excTval), .csrRdata(csrRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] pc, input logic [31:0] x7);
    @(negedge clk);
    instValid = 1; instWord = w; instPc = pc; x7Value = x7;
    #(CLK_PERIOD/4);
    sExc = excValid; sCause = excCause; sTval = excTval;
    @(posedge clk); #1;
    instValid = 0;
  endtask

  task automatic pulseTrap();
    @(negedge clk); trapEnter = 1;
    @(posedge clk); #1; trapEnter = 0;
  endtask

  task automatic pulseMret();
    @(negedge clk); mretDone = 1;
    @(posedge clk); #1; mretDone = 0;
  endtask

  task automatic csrWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); csrWe = 1; csrAddr = a; csrWdata = d;
    @(posedge clk); #1; csrWe = 0;
  endtask

  task automatic csrRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); csrAddr = a; #1; d = csrRdata;
  endtask

  // probe: ordinary instruction after an arming jump; clears flag via trap if it faults
  task automatic probe(input string req, input logic expFault);
    issue(NOP, 32'h200, 0);
    check(req, {31'd0, sExc}, {31'd0, expFault});
    if (sExc) begin pulseTrap(); csrWrite(12'h310, 0); end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    csrRead(12'h747, d); check("R1 seccfg reset", d, 0);
    csrRead(12'h310, d); check("R1 statush reset", d, 0);
    issue(JALR_X6, 32'h100, X7A); check("R1 no exc jalr", {31'd0, sExc}, 0);
    issue(NOP, 32'h104, 0); check("R1 no exc after", {31'd0, sExc}, 0);
  endtask

  task automatic t_csr();
    logic [31:0] d;
    csrWrite(12'h747, 32'hFFFF_FFFF); csrRead(12'h747, d); check("R2 seccfg bit10", d, 32'h400);
    csrWrite(12'h310, 32'hFFFF_FFFF); csrRead(12'h310, d); check("R2 statush bit9", d, 32'h200);
    csrWrite(12'h300, 32'hFFFF_FFFF); csrRead(12'h300, d); check("R2 other addr", d, 0);
    csrWrite(12'h310, 0); csrRead(12'h310, d); check("R2 statush clear", d, 0);
  endtask

  task automatic t_wide();
    issue(JALR_X6, 32'h100, X7A); probe("R3 jalr x6 arms", 1);
    issue(32'h0000_8067, 32'h100, X7A); probe("R3 jalr x1 exempt", 0);
    issue(32'h0002_8067, 32'h100, X7A); probe("R3 jalr x5 exempt", 0);
    issue(32'h0003_8067, 32'h100, X7A); probe("R3 jalr x7 exempt", 0);
    issue(32'h0003_1067, 32'h100, X7A); probe("R3 funct3 nonzero", 0);
  endtask

  task automatic t_short();
    issue(32'h0000_8302, 32'h100, X7A); probe("R4 c.jr x6 arms", 1);
    issue(32'h0000_9302, 32'h100, X7A); probe("R4 c.jalr x6 arms", 1);
    issue(32'h0000_8082, 32'h100, X7A); probe("R4 c.jr x1 exempt", 0);
    issue(32'h0000_9282, 32'h100, X7A); probe("R4 c.jalr x5 exempt", 0);
    issue(32'h0000_8300, 32'h100, X7A); probe("R4 quadrant0", 0);
    issue(32'h0000_A302, 32'h100, X7A); probe("R4 bits15:12 A", 0);
  endtask

  task automatic t_pad();
    issue(JALR_X6, 32'h100, X7A);
    issue(32'h1234_5017, 32'h300, 0); check("R5 matching pad", {31'd0, sExc}, 0);
    probe("R7 pass clears flag", 0);
    issue(JALR_X6, 32'h100, X7A);
    issue(32'h0000_0017, 32'h300, 0); check("R5 zero label pad", {31'd0, sExc}, 0);
    issue(JALR_X6, 32'h100, X7A);
    issue(32'h1111_1017, 32'h300, 0); check("R5 wrong label", {31'd0, sExc}, 1);
    pulseTrap(); csrWrite(12'h310, 0);
    issue(JALR_X6, 32'h100, X7A);
    issue(32'h1234_5017, 32'h302, 0); check("R5 misaligned", {31'd0, sExc}, 1);
    pulseTrap(); csrWrite(12'h310, 0);
    issue(JALR_X6, 32'h100, X7A);
    issue(32'h1234_5037, 32'h300, 0); check("R5 wrong opcode", {31'd0, sExc}, 1);
    pulseTrap(); csrWrite(12'h310, 0);
  endtask

  task automatic t_fault();
    issue(JALR_X6, 32'h100, X7A);
    @(negedge clk); #1; check("R11 no exc without valid", {31'd0, excValid}, 0);
    issue(NOP, 32'h200, 0);
    check("R6 exc valid", {31'd0, sExc}, 1);
    check("R6 cause", sCause, 32'd18);
    check("R6 tval", sTval, 32'd2);
    issue(NOP, 32'h204, 0); check("R6 flag held", {31'd0, sExc}, 1);
    pulseTrap(); csrWrite(12'h310, 0);
  endtask

  task automatic t_trapMret();
    logic [31:0] d;
    issue(JALR_X6, 32'h100, X7A);
    pulseTrap();
    csrRead(12'h310, d); check("R9 saved set", d, 32'h200);
    issue(NOP, 32'h200, 0); check("R9 flag cleared", {31'd0, sExc}, 0);
    pulseMret();
    csrRead(12'h310, d); check("R10 saved cleared", d, 0);
    issue(32'h1234_5017, 32'h300, 0); check("R10 label kept", {31'd0, sExc}, 0);
    issue(JALR_X6, 32'h100, X7A);
    pulseTrap(); pulseMret();
    probe("R10 flag restored", 1);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    csrWrite(12'h747, 0);
    issue(JALR_X6, 32'h100, X7A);
    issue(NOP, 32'h200, 0); check("R8 no arm", {31'd0, sExc}, 0);
    csrWrite(12'h747, 32'h400);
    issue(JALR_X6, 32'h100, X7A);
    csrWrite(12'h747, 0);
    pulseTrap();
    csrRead(12'h310, d); check("R9 and with enable", d, 0);
    csrWrite(12'h310, 32'h200);
    pulseMret();
    csrWrite(12'h747, 32'h400);
    issue(NOP, 32'h200, 0); check("R10 and with enable", {31'd0, sExc}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_csr();
    csrWrite(12'h747, 32'h400);
    t_wide();
    t_short();
    t_pad();
    t_fault();
    t_trapMret();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule